// File: doc/BRIEF.md
# General-Purpose Event Register Block

This block keeps two 16-bit words for power-management general-purpose events: a status word that records which events have happened and an enable word that software uses to select which of them may interrupt. A host reaches both words through single-byte reads and writes in a four-byte window. The window starts at a base I/O address set by a parameter. The low two bytes of the window hold the status word and the upper two hold the enable word. Writes to a status byte clear bits (write-one-to-clear). Writes to an enable byte overwrite that byte.

Hardware sources set status bits. A generic event vector can set any status bit. Slot insert and slot remove pulses each set a fixed hotplug status bit, and each one also records its slot number in a 32-bit sticky bitmap. The system control interrupt (SCI) output is a level, not a pulse. It is high while the externally combined fixed-event request is high, or while the hotplug bit is both pending and enabled.

Top module: `gpe_event_block`

## Requirements
- R1: After reset the status word, the enable word, both slot bitmaps and the read data register are all zero, and `sci` is low while `pmFixedIrq` is low.
- R2: A read at window offset 0/1 returns status bits 7:0 / 15:8, and a read at offset 2/3 returns enable bits 7:0 / 15:8. The byte appears on `hostRData` one clock after the strobe and holds until the next read.
- R3: A write to offset 0 or 1 clears each status bit of that byte wherever the written data has a one. It leaves the other status byte and the enable word unchanged.
- R4: A write to offset 2 or 3 replaces only that byte of the enable word with the written data. The status word is not changed.
- R5: An access outside `[BASE_ADDR, BASE_ADDR+3]` does not change any register. A read there returns 0x00.
- R6: `sci` equals `pmFixedIrq` OR (status bit 1 AND enable bit 1). Other status/enable bit pairs have no effect on `sci`.
- R7: A cycle with `slotInsert` high sets status bit 1 and bit `slotNum` of `upMap`. Bits of `upMap` never clear, except at reset.
- R8: A cycle with `slotRemove` high sets status bit 1 and bit `slotNum` of `downMap`. Bits of `downMap` never clear, except at reset.
- R9: When a hardware source sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R10: A status-clear or enable write that changes the hotplug term is visible on `sci` in the cycle after the write strobe.
- R11: Each bit of `gpeEvent` that is high in a cycle sets the matching status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostValid | input | 1 | One-cycle access strobe |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 16 | Byte I/O address |
| hostWData | input | 8 | Write data byte |
| hostRData | output | 8 | Registered read data byte |
| gpeEvent | input | 16 | Per-bit status set pulses |
| pmFixedIrq | input | 1 | Combined fixed-event interrupt request |
| slotInsert | input | 1 | Device-inserted pulse |
| slotRemove | input | 1 | Device-removed pulse |
| slotNum | input | 5 | Slot index for insert/remove |
| upMap | output | 32 | Sticky inserted-slot bitmap |
| downMap | output | 32 | Sticky removed-slot bitmap |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
The assertions check several rules on every cycle:
- write-one-to-clear leaves the other byte lane alone;
- an enable write lands in its lane;
- a hotplug pulse always leaves bit 1 set, even when a clear hits it in the same cycle;
- the bitmaps only grow;
- a read outside the window returns zero;
- dropping the hotplug enable pulls `sci` down on the next cycle.

Only the bench scenarios can show the full byte-lane read mapping, the decode limits at both edges of the window, and that `sci` ignores other enabled status bits. They can also show that random mixes of accesses and events keep both words consistent with an independent model over long runs.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  // Word geometry of the event block: two 16-bit words, byte accessed.
  localparam int GPE_WORD_W   = 16;
  localparam int GPE_LANES    = GPE_WORD_W / 8;
  localparam int GPE_LANE_W   = (GPE_LANES > 1) ? $clog2(GPE_LANES) : 1;
  localparam int GPE_WIN_BYTES = 2 * GPE_LANES;

  // Strobes passed from the decode control to the datapath.
  typedef struct packed {
    logic [GPE_LANES-1:0]  stsWr;   // clear-by-one write into a status lane
    logic [GPE_LANES-1:0]  enWr;    // replace write into an enable lane
    logic                  rdEn;    // any read access this cycle
    logic                  rdHit;   // read falls inside the window
    logic                  rdIsEn;  // read selects the enable word
    logic [GPE_LANE_W-1:0] rdLane;  // byte lane selected for read
  } gpeStrobe_t;
endpackage

// File: rtl/gpe_ctrl.sv
module gpe_ctrl
  import gpe_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAFE0
) (
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  output gpeStrobe_t        strobe
);
  logic [ADDR_W-1:0]     offset;
  logic                  inWindow;
  logic                  wordIsEn;
  logic [GPE_LANE_W-1:0] lane;

  always_comb begin
    offset   = hostAddr - BASE_ADDR;
    inWindow = (hostAddr >= BASE_ADDR) && (offset < ADDR_W'(GPE_WIN_BYTES));
    wordIsEn = offset[GPE_LANE_W];
    lane     = offset[GPE_LANE_W-1:0];
  end

  always_comb begin
    strobe        = '0;
    strobe.rdEn   = hostValid && !hostWrite;
    strobe.rdHit  = inWindow;
    strobe.rdIsEn = wordIsEn;
    strobe.rdLane = lane;
    for (int l = 0; l < GPE_LANES; l++) begin
      strobe.stsWr[l] = hostValid && hostWrite && inWindow && !wordIsEn &&
                        (lane == GPE_LANE_W'(l));
      strobe.enWr[l]  = hostValid && hostWrite && inWindow && wordIsEn &&
                        (lane == GPE_LANE_W'(l));
    end
  end
endmodule

// File: rtl/gpe_datapath.sv
module gpe_datapath
  import gpe_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int HP_BIT = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gpeStrobe_t            strobe,
  input  logic [7:0]            hostWData,
  input  logic [GPE_WORD_W-1:0] gpeEvent,
  input  logic                  pmFixedIrq,
  input  logic                  slotInsert,
  input  logic                  slotRemove,
  input  logic [SLOT_W-1:0]     slotNum,
  output logic [7:0]            hostRData,
  output logic [SLOTS-1:0]      upMap,
  output logic [SLOTS-1:0]      downMap,
  output logic                  sci
);
  localparam int HP_LANE = HP_BIT / 8;
  localparam int HP_POS  = HP_BIT % 8;

  logic [GPE_WORD_W-1:0] stsWord, enWord;
  logic [GPE_WORD_W-1:0] stsNext, enNext, evtSet;
  logic [GPE_WORD_W-1:0] rdWord;
  logic [7:0]            rdByte;
  logic [SLOTS-1:0]      upNext, downNext;

  // Hardware set sources: generic vector plus the hotplug bit.
  always_comb begin
    evtSet = gpeEvent;
    if (slotInsert || slotRemove) evtSet[HP_BIT] = 1'b1;
  end

  // Per-lane merge: clear-by-one first, then OR in sets (set wins).
  for (genvar gl = 0; gl < GPE_LANES; gl++) begin : g_lane
    always_comb begin
      stsNext[gl*8 +: 8] = (strobe.stsWr[gl] ? (stsWord[gl*8 +: 8] & ~hostWData)
                                             : stsWord[gl*8 +: 8])
                           | evtSet[gl*8 +: 8];
      enNext[gl*8 +: 8]  = strobe.enWr[gl] ? hostWData : enWord[gl*8 +: 8];
    end
  end

  // Slot decode into the sticky bitmaps.
  for (genvar gs = 0; gs < SLOTS; gs++) begin : g_slot
    assign upNext[gs]   = upMap[gs]   | (slotInsert && (slotNum == SLOT_W'(gs)));
    assign downNext[gs] = downMap[gs] | (slotRemove && (slotNum == SLOT_W'(gs)));
  end

  always_comb begin
    rdWord = strobe.rdIsEn ? enWord : stsWord;
    rdByte = rdWord[strobe.rdLane*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsWord   <= '0;
      enWord    <= '0;
      upMap     <= '0;
      downMap   <= '0;
      hostRData <= '0;
    end else begin
      stsWord <= stsNext;
      enWord  <= enNext;
      upMap   <= upNext;
      downMap <= downNext;
      if (strobe.rdEn) hostRData <= strobe.rdHit ? rdByte : 8'h00;
    end
  end

  // Level output straight from the registered words.
  assign sci = pmFixedIrq | (stsWord[HP_BIT] & enWord[HP_BIT]);

  AST_STS_W1C_LO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stsWr[0] && (evtSet[7:0] == 8'h00)) |=>
      ((stsWord[7:0] & $past(hostWData)) == 8'h00)); // R3
  AST_STS_OTHER_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stsWr[0] && !strobe.stsWr[1] && (evtSet[15:8] == 8'h00)) |=>
      (stsWord[15:8] == $past(stsWord[15:8]))); // R3
  AST_EN_REPLACE_HI: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enWr[1] |=> (enWord[15:8] == $past(hostWData))); // R4
  AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && !strobe.rdHit) |=> (hostRData == 8'h00)); // R5
  AST_HP_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (slotInsert || slotRemove) |=> stsWord[HP_BIT]); // R9
  AST_INS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    slotInsert |=> upMap[$past(slotNum)]); // R7
  AST_UP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((upMap & $past(upMap)) == $past(upMap))); // R7
  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((downMap & $past(downMap)) == $past(downMap))); // R8
  AST_SCI_EN_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enWr[HP_LANE] && !hostWData[HP_POS]) |=> (pmFixedIrq || !sci)); // R10
endmodule

// File: rtl/gpe_event_block.sv
module gpe_event_block
  import gpe_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAFE0,
  parameter int                SLOTS     = 32,
  parameter int                SLOT_W    = $clog2(SLOTS),
  parameter int                HP_BIT    = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostValid,
  input  logic                  hostWrite,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [7:0]            hostWData,
  output logic [7:0]            hostRData,
  input  logic [GPE_WORD_W-1:0] gpeEvent,
  input  logic                  pmFixedIrq,
  input  logic                  slotInsert,
  input  logic                  slotRemove,
  input  logic [SLOT_W-1:0]     slotNum,
  output logic [SLOTS-1:0]      upMap,
  output logic [SLOTS-1:0]      downMap,
  output logic                  sci
);
  gpeStrobe_t strobe;

  gpe_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) ctrl_i (
    .hostValid(hostValid),
    .hostWrite(hostWrite),
    .hostAddr (hostAddr),
    .strobe   (strobe)
  );

  gpe_datapath #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .HP_BIT(HP_BIT)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWData (hostWData),
    .gpeEvent  (gpeEvent),
    .pmFixedIrq(pmFixedIrq),
    .slotInsert(slotInsert),
    .slotRemove(slotRemove),
    .slotNum   (slotNum),
    .hostRData (hostRData),
    .upMap     (upMap),
    .downMap   (downMap),
    .sci       (sci)
  );

  AST_PM_PASS: assert property (@(posedge clk) disable iff (!rstN)
    pmFixedIrq |-> sci); // R6
endmodule

// File: tb/gpe_event_block_tb_top.sv
`timescale 1ns/1ps
module gpe_event_block_tb_top;
  localparam logic [15:0] BASE = 16'hAFE0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0, hostWrite = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostWData = '0;
  logic [7:0]  hostRData;
  logic [15:0] gpeEvent = '0;
  logic        pmFixedIrq = 1'b0, slotInsert = 1'b0, slotRemove = 1'b0;
  logic [4:0]  slotNum = '0;
  logic [31:0] upMap, downMap;
  logic        sci;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state
  logic [15:0] mSts = '0, mEn = '0;
  logic [31:0] mUp = '0, mDown = '0;
  logic [7:0]  mRd = '0;

  always #5 clk = ~clk;

  gpe_event_block dut_i (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWData(hostWData), .hostRData(hostRData),
    .gpeEvent(gpeEvent), .pmFixedIrq(pmFixedIrq), .slotInsert(slotInsert),
    .slotRemove(slotRemove), .slotNum(slotNum), .upMap(upMap),
    .downMap(downMap), .sci(sci)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit inWin(input logic [15:0] a);
    return (a >= BASE) && (a <= BASE + 16'd3);
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a,
                                         input logic [15:0] s, input logic [15:0] e);
    logic [15:0] off;
    logic [15:0] w;
    off = a - BASE;
    if (!inWin(a)) return 8'h00;
    w = off[1] ? e : s;
    return off[0] ? w[15:8] : w[7:0];
  endfunction

  // One bus/event cycle; checks outputs after the capturing edge.
  task automatic step(input logic v, input logic w, input logic [15:0] a,
                      input logic [7:0] d, input logic [15:0] ev,
                      input logic ins, input logic rem, input logic [4:0] sl,
                      input logic pm);
    logic [15:0] nSts, nEn, off;
    logic [31:0] nUp, nDown;
    logic [7:0]  nRd;
    hostValid = v; hostWrite = w; hostAddr = a; hostWData = d;
    gpeEvent = ev; slotInsert = ins; slotRemove = rem; slotNum = sl; pmFixedIrq = pm;
    off = a - BASE;
    nSts = mSts; nEn = mEn; nUp = mUp; nDown = mDown; nRd = mRd;
    if (v && w && inWin(a)) begin
      if (!off[1]) begin
        if (off[0]) nSts[15:8] = nSts[15:8] & ~d; else nSts[7:0] = nSts[7:0] & ~d;
      end else begin
        if (off[0]) nEn[15:8] = d; else nEn[7:0] = d;
      end
    end
    nSts = nSts | ev;
    if (ins || rem) nSts[1] = 1'b1;
    if (ins) nUp[sl] = 1'b1;
    if (rem) nDown[sl] = 1'b1;
    if (v && !w) nRd = expRead(a, mSts, mEn);
    @(posedge clk);
    @(negedge clk);
    mSts = nSts; mEn = nEn; mUp = nUp; mDown = nDown; mRd = nRd;
    hostValid = 1'b0; slotInsert = 1'b0; slotRemove = 1'b0; gpeEvent = '0;
    check("R6", "sci", {31'b0, sci}, {31'b0, pm | (mSts[1] & mEn[1])});
    check("R7", "upMap", upMap, mUp);
    check("R8", "downMap", downMap, mDown);
    check(inWin(a) ? "R2" : "R5", "hostRData", {24'b0, hostRData}, {24'b0, mRd});
  endtask

  task automatic rd(input logic [15:0] a);
    step(1'b1, 1'b0, a, 8'h00, 16'h0, 1'b0, 1'b0, 5'd0, 1'b0);
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    step(1'b1, 1'b1, a, d, 16'h0, 1'b0, 1'b0, 5'd0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", "sci", {31'b0, sci}, 32'd0);
    check("R1", "upMap", upMap, 32'd0);
    check("R1", "downMap", downMap, 32'd0);
    check("R1", "hostRData", {24'b0, hostRData}, 32'd0);
    for (int i = 0; i < 4; i++) rd(BASE + 16'(i));

    // R4/R2: enable lanes written separately, read back
    wr(BASE + 16'd2, 8'hA5);
    wr(BASE + 16'd3, 8'h3C);
    rd(BASE + 16'd2); check("R4", "en lo", {24'b0, hostRData}, 32'hA5);
    rd(BASE + 16'd3); check("R4", "en hi", {24'b0, hostRData}, 32'h3C);

    // R11 and R3: set high-lane bits, clear some, lower lane untouched
    step(1'b0, 1'b0, 16'h0, 8'h0, 16'hF00F, 1'b0, 1'b0, 5'd0, 1'b0);
    wr(BASE + 16'd1, 8'h30);
    rd(BASE + 16'd1); check("R3", "sts hi", {24'b0, hostRData}, 32'hC0);
    rd(BASE + 16'd0); check("R11", "sts lo", {24'b0, hostRData}, 32'h0F);

    // R6: enabled non-hotplug bits (bit 0, bit 2 with en 0xA5) do not raise sci
    check("R6", "sci other bits", {31'b0, sci}, 32'd0);

    // R7: insert slot 31 with hotplug enable on -> sci high
    wr(BASE + 16'd2, 8'h02);
    step(1'b0, 1'b0, 16'h0, 8'h0, 16'h0, 1'b1, 1'b0, 5'd31, 1'b0);
    check("R7", "up slot31", {31'b0, upMap[31]}, 32'd1);
    check("R7", "sci hp", {31'b0, sci}, 32'd1);

    // R10: drop the enable -> sci low the cycle after
    wr(BASE + 16'd2, 8'h00);
    check("R10", "sci after en clear", {31'b0, sci}, 32'd0);
    wr(BASE + 16'd2, 8'h02);
    wr(BASE + 16'd0, 8'h02);
    check("R10", "sci after sts clear", {31'b0, sci}, 32'd0);

    // R9: clear and removal in the same cycle -> bit stays set
    step(1'b1, 1'b1, BASE, 8'hFF, 16'h0, 1'b0, 1'b1, 5'd0, 1'b0);
    check("R9", "sci collision", {31'b0, sci}, 32'd1);
    check("R8", "down slot0", {31'b0, downMap[0]}, 32'd1);

    // R5: writes just outside both edges do nothing
    wr(BASE - 16'd1, 8'hFF);
    wr(BASE + 16'd4, 8'hFF);
    rd(BASE + 16'd2); check("R5", "en unchanged", {24'b0, hostRData}, 32'h02);
    rd(BASE + 16'd4); check("R5", "miss read", {24'b0, hostRData}, 32'h00);

    // R6: fixed-event request passes through
    step(1'b0, 1'b0, 16'h0, 8'h0, 16'h0, 1'b0, 1'b0, 5'd0, 1'b1);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      int unsigned r;
      r = $urandom % 16;
      if (r < 12) a = BASE + 16'($urandom % 4);
      else if (r == 12) a = BASE + 16'd4;
      else if (r == 13) a = BASE - 16'd1;
      else a = 16'($urandom);
      step(($urandom % 4) != 0, ($urandom % 2) == 1, a, 8'($urandom),
           (($urandom % 8) == 0) ? 16'($urandom) : 16'h0,
           ($urandom % 10) == 0, ($urandom % 12) == 0, 5'($urandom),
           ($urandom % 9) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule